// File: doc/BRIEF.md
# Windowed Command and Interrupt Status Unit

This block is the control port of a network adapter register file. The host writes one 16-bit command word: a 5-bit opcode sits above an 11-bit argument. The same offset, when read, returns a status word. That word carries the selected register window in its top three bits, a busy flag, and the latched interrupt causes. The unit keeps the window selection, the interrupt-enable mask, the indication mask (which causes a status read can see), the receive filter and three 11-bit thresholds. It also drives the interrupt line.

Events from the data paths arrive as one-cycle pulses and set cause bits. The host can raise a cause itself, clear causes, and mask them. The reset commands make the unit report busy for a fixed number of cycles, and the host polls the busy flag until it drops. The command port takes one write per cycle and never stalls, so it is a plain strobe with no valid/ready pair. The status word is combinational from registers. All outputs are plain control levels.

Top module: `winctl_unit`

## Requirements
- R1: A write (`cmd_wr` high at a rising edge) is decoded as opcode = `cmd_data[15:11]` and argument = `cmd_data[10:0]`. An opcode not listed below (for example 0x1F) changes no state and no output.
- R2: Opcode 0x01 stores argument bits 2:0 as the window. Argument bits 10:3 are ignored. From the next cycle the window appears on `win_sel` and in `status_word[15:13]`.
- R3: Each event pulse sets its cause bit, visible from the next cycle, and the bit stays set until it is cleared. The bits are: host error bit 1, tx complete bit 2, tx space available bit 3, rx complete bit 4, rx early bit 5, statistics update bit 7, transfer done bit 8.
- R4: Opcode 0x0C sets the interrupt-requested cause, bit 6.
- R5: Opcode 0x0D clears every cause bit and the latch bit 0 wherever argument bits 8:0 are one. A cause that is raised in the same cycle stays set.
- R6: Opcode 0x0E stores argument bits 8:0 as the interrupt-enable mask. The latch (bit 0) is set in the cycle after a cause within 0x1FE is newly raised while its enable bit is set.
- R7: `irq_out` is high exactly when the latch is set and (causes & enable & 0x1FE) is non-zero.
- R8: Opcode 0x0F stores argument bits 8:0 as the indication mask. `status_word[8:0]` equals {causes, latch} ANDed with this mask, and `status_word[11:9]` reads zero. Hidden causes still count for R7.
- R9: Opcode 0x10 stores argument bits 3:0 on `rx_filter`: bit 0 station address, bit 1 multicast, bit 2 broadcast, bit 3 all frames.
- R10: Opcodes 0x11, 0x12 and 0x13 store the 11-bit argument on `rx_early_thr`, `tx_avail_thr` and `tx_start_thr` respectively.
- R11: Opcodes 0x05 (rx reset) and 0x0B (tx reset) make `status_word[12]` high for exactly BUSY_CYCLES cycles, starting the cycle after the write. A new reset command restarts that count.
- R12: Opcode 0x00 (global reset) returns every stored value and cause to zero, overriding any event pulse in the same cycle, and starts the busy count of R11.
- R13: After `rst_n` low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: opcode 15:11, argument 10:0 |
| ev_host_err | input | 1 | Host error event pulse |
| ev_tx_done | input | 1 | Transmit complete pulse |
| ev_tx_room | input | 1 | Transmit space available pulse |
| ev_rx_done | input | 1 | Receive complete pulse |
| ev_rx_early | input | 1 | Receive early pulse |
| ev_stats | input | 1 | Statistics update pulse |
| ev_xfer_done | input | 1 | Bus-master transfer done pulse |
| status_word | output | 16 | Window, busy flag, visible causes and latch |
| irq_out | output | 1 | Interrupt request |
| win_sel | output | 3 | Selected register window |
| rx_filter | output | 4 | Receive filter bits |
| rx_early_thr | output | 11 | Rx early threshold |
| tx_avail_thr | output | 11 | Tx space-available threshold |
| tx_start_thr | output | 11 | Tx start threshold |

## Verification
Two collisions matter here. The first is an acknowledge that clears a cause in the same cycle as an event pulse that raises that cause. The bench lands the pulse and the acknowledge on the same edge and expects the cause to survive. The second is a global reset that meets an event pulse; there the bench expects every bit to read zero. A behavioural model predicts the whole output set on every clock, so any slip in precedence or timing shows up in the cycle where it happens.

// File: rtl/winctl_pkg.sv
package winctl_pkg;
  localparam int CMD_W = 16;
  localparam int OP_W  = 5;
  localparam int ARG_W = 11;
  localparam int CAUSE_W = 9;
  localparam int THR_N = 3;

  localparam logic [CAUSE_W-1:0] IRQ_CAUSES = 9'h1FE;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RST = 5'h00,
    OP_WINDOW     = 5'h01,
    OP_RX_RST     = 5'h05,
    OP_TX_RST     = 5'h0B,
    OP_REQUEST    = 5'h0C,
    OP_ACK        = 5'h0D,
    OP_IRQ_EN     = 5'h0E,
    OP_VIS_EN     = 5'h0F,
    OP_FILTER     = 5'h10,
    OP_THR_RXE    = 5'h11,
    OP_THR_TXA    = 5'h12,
    OP_THR_TXS    = 5'h13
  } opcode_e;

  typedef struct packed {
    logic             clear_all;
    logic             win_wr;
    logic             busy_go;
    logic             req;
    logic             ack;
    logic             ien_wr;
    logic             vis_wr;
    logic             filt_wr;
    logic [THR_N-1:0] thr_wr;
  } cmd_strobe_t;
endpackage

// File: rtl/winctl_decode.sv
module winctl_decode
  import winctl_pkg::*;
(
  input  logic              wr,
  input  logic [CMD_W-1:0]  word,
  output cmd_strobe_t       strobe,
  output logic [ARG_W-1:0]  arg
);
  logic [OP_W-1:0] op;

  assign op  = word[CMD_W-1 -: OP_W];
  assign arg = word[ARG_W-1:0];

  always_comb begin
    strobe = '0;
    if (wr) begin
      case (op)
        OP_GLOBAL_RST: begin strobe.clear_all = 1'b1; strobe.busy_go = 1'b1; end
        OP_WINDOW:     strobe.win_wr  = 1'b1;
        OP_RX_RST:     strobe.busy_go = 1'b1;
        OP_TX_RST:     strobe.busy_go = 1'b1;
        OP_REQUEST:    strobe.req     = 1'b1;
        OP_ACK:        strobe.ack     = 1'b1;
        OP_IRQ_EN:     strobe.ien_wr  = 1'b1;
        OP_VIS_EN:     strobe.vis_wr  = 1'b1;
        OP_FILTER:     strobe.filt_wr = 1'b1;
        OP_THR_RXE:    strobe.thr_wr[0] = 1'b1;
        OP_THR_TXA:    strobe.thr_wr[1] = 1'b1;
        OP_THR_TXS:    strobe.thr_wr[2] = 1'b1;
        default:       strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/winctl_busy.sv
module winctl_busy #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain_q <= '0;
    else if (start)
      remain_q <= LOAD;
    else if (remain_q != '0)
      remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/winctl_cause.sv
module winctl_cause
  import winctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_all,
  input  logic [CAUSE_W-1:0] raise,
  input  logic               ack,
  input  logic [CAUSE_W-1:0] ack_bits,
  input  logic [CAUSE_W-1:0] enable,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               irq
);
  logic [CAUSE_W-1:0] drop;
  logic [CAUSE_W-1:0] nxt;
  logic               fresh_hit;

  assign drop      = ack ? ack_bits : '0;
  assign fresh_hit = |(raise & enable & IRQ_CAUSES);

  always_comb begin
    nxt = (cause_q & ~drop) | (raise & IRQ_CAUSES);
    nxt[0] = (cause_q[0] & ~drop[0]) | fresh_hit;
    if (clear_all)
      nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cause_q <= '0;
    else
      cause_q <= nxt;
  end

  assign irq = cause_q[0] & (|(cause_q & enable & IRQ_CAUSES));
endmodule

// File: rtl/winctl_unit.sv
module winctl_unit
  import winctl_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [15:0]       cmd_data,
  input  logic              ev_host_err,
  input  logic              ev_tx_done,
  input  logic              ev_tx_room,
  input  logic              ev_rx_done,
  input  logic              ev_rx_early,
  input  logic              ev_stats,
  input  logic              ev_xfer_done,
  output logic [15:0]       status_word,
  output logic              irq_out,
  output logic [2:0]        win_sel,
  output logic [3:0]        rx_filter,
  output logic [10:0]       rx_early_thr,
  output logic [10:0]       tx_avail_thr,
  output logic [10:0]       tx_start_thr
);
  cmd_strobe_t        stb;
  logic [ARG_W-1:0]   arg;
  logic [CAUSE_W-1:0] ev_set;
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] ien_q;
  logic [CAUSE_W-1:0] vis_q;
  logic [2:0]         win_q;
  logic [3:0]         filt_q;
  logic [ARG_W-1:0]   thr_q [THR_N];
  logic               busy;

  winctl_decode i_dec (
    .wr     (cmd_wr),
    .word   (cmd_data),
    .strobe (stb),
    .arg    (arg)
  );

  assign ev_set = {ev_xfer_done, ev_stats, stb.req, ev_rx_early,
                   ev_rx_done, ev_tx_room, ev_tx_done, ev_host_err, 1'b0};

  winctl_cause i_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (stb.clear_all),
    .raise     (ev_set),
    .ack       (stb.ack),
    .ack_bits  (arg[CAUSE_W-1:0]),
    .enable    (ien_q),
    .cause_q   (cause_q),
    .irq       (irq_out)
  );

  winctl_busy #(.CYCLES(BUSY_CYCLES)) i_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (stb.busy_go),
    .busy  (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      ien_q  <= '0;
      vis_q  <= '0;
      filt_q <= '0;
    end else if (stb.clear_all) begin
      win_q  <= '0;
      ien_q  <= '0;
      vis_q  <= '0;
      filt_q <= '0;
    end else begin
      if (stb.win_wr)  win_q  <= arg[2:0];
      if (stb.ien_wr)  ien_q  <= arg[CAUSE_W-1:0];
      if (stb.vis_wr)  vis_q  <= arg[CAUSE_W-1:0];
      if (stb.filt_wr) filt_q <= arg[3:0];
    end
  end

  for (genvar g = 0; g < THR_N; g++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_q[g] <= '0;
      else if (stb.clear_all)
        thr_q[g] <= '0;
      else if (stb.thr_wr[g])
        thr_q[g] <= arg;
    end
  end

  assign status_word  = {win_q, busy, 3'b000, cause_q & vis_q};
  assign win_sel      = win_q;
  assign rx_filter    = filt_q;
  assign rx_early_thr = thr_q[0];
  assign tx_avail_thr = thr_q[1];
  assign tx_start_thr = thr_q[2];
endmodule

// File: rtl/winctl_checker.sv
module winctl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [15:0] status_word,
  input logic        irq_out,
  input logic [2:0]  win_sel,
  input logic [8:0]  ev_vec,
  input logic [8:0]  cause_vec
);
  logic [4:0] op;
  assign op = cmd_data[15:11];

  assert_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == 5'h01) |=> (win_sel == $past(cmd_data[2:0])));

  assert_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec[4] && !(cmd_wr && op == 5'h00)) |=> cause_vec[4]);

  assert_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == 5'h0C) |=> cause_vec[6]);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == 5'h0D && ev_vec == 9'h000) |=>
      ((cause_vec & $past(cmd_data[8:0])) == 9'h000));

  assert_irq_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> cause_vec[0]);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[11:9] == 3'b000);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && (op == 5'h05 || op == 5'h0B)) |=> status_word[12]);

  assert_global_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == 5'h00) |=> (cause_vec == 9'h000 && win_sel == 3'd0));
endmodule

bind winctl_unit winctl_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_wr      (cmd_wr),
  .cmd_data    (cmd_data),
  .status_word (status_word),
  .irq_out     (irq_out),
  .win_sel     (win_sel),
  .ev_vec      (ev_set),
  .cause_vec   (cause_q)
);

// File: tb/test_winctl_unit.sv
module test_winctl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NBUSY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic ev_host_err = 0, ev_tx_done = 0, ev_tx_room = 0, ev_rx_done = 0;
  logic ev_rx_early = 0, ev_stats = 0, ev_xfer_done = 0;
  logic [15:0] status_word;
  logic irq_out;
  logic [2:0] win_sel;
  logic [3:0] rx_filter;
  logic [10:0] rx_early_thr, tx_avail_thr, tx_start_thr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int m_win, m_ien, m_vis, m_filt, m_cause, m_busy;
  int m_thr [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  winctl_unit #(.BUSY_CYCLES(NBUSY)) i_winctl_unit (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ev_host_err(ev_host_err), .ev_tx_done(ev_tx_done), .ev_tx_room(ev_tx_room),
    .ev_rx_done(ev_rx_done), .ev_rx_early(ev_rx_early), .ev_stats(ev_stats),
    .ev_xfer_done(ev_xfer_done), .status_word(status_word), .irq_out(irq_out),
    .win_sel(win_sel), .rx_filter(rx_filter), .rx_early_thr(rx_early_thr),
    .tx_avail_thr(tx_avail_thr), .tx_start_thr(tx_start_thr)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_clear();
    m_win = 0; m_ien = 0; m_vis = 0; m_filt = 0; m_cause = 0;
    for (int i = 0; i < 3; i++) m_thr[i] = 0;
  endfunction

  // Reference model: next state from the inputs seen at this edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
      m_busy = 0;
    end else begin
      int op, arg, raise, drop, old_ien;
      op = cmd_wr ? int'(cmd_data[15:11]) : -1;
      arg = int'(cmd_data[10:0]);
      old_ien = m_ien;
      raise = (ev_host_err << 1) | (ev_tx_done << 2) | (ev_tx_room << 3) |
              (ev_rx_done << 4) | (ev_rx_early << 5) | ((op == 12) << 6) |
              (ev_stats << 7) | (ev_xfer_done << 8);
      if (m_busy > 0) m_busy--;
      if (op == 0) begin
        model_clear();
        m_busy = NBUSY;
      end else begin
        drop = (op == 13) ? (arg & 'h1FF) : 0;
        if ((raise & old_ien & 'h1FE) != 0) m_cause = (m_cause & ~drop) | raise | 1;
        else m_cause = (m_cause & ~drop) | raise;
        case (op)
          1: m_win = arg & 7;
          5, 11: m_busy = NBUSY;
          14: m_ien = arg & 'h1FF;
          15: m_vis = arg & 'h1FF;
          16: m_filt = arg & 'hF;
          17: m_thr[0] = arg;
          18: m_thr[1] = arg;
          19: m_thr[2] = arg;
          default: ;
        endcase
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_irq;
      exp_irq = ((m_cause & 1) != 0 && (m_cause & m_ien & 'h1FE) != 0) ? 1 : 0;
      check("R2 window field", int'(status_word[15:13]), m_win);
      check("R2 win_sel", int'(win_sel), m_win);
      check("R11 busy flag", int'(status_word[12]), (m_busy > 0) ? 1 : 0);
      check("R8 visible causes", int'(status_word[11:0]), m_cause & m_vis);
      check("R7 irq", int'(irq_out), exp_irq);
      check("R9 filter", int'(rx_filter), m_filt);
      check("R10 thresholds", {rx_early_thr, tx_avail_thr, tx_start_thr},
            {m_thr[0][10:0], m_thr[1][10:0], m_thr[2][10:0]});
    end
  end

  task automatic cmd(int op, int arg);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_data = {op[4:0], arg[10:0]};
    @(negedge clk);
    cmd_wr = 1'b0;
    cmd_data = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R13 reset state
    check("R13 status after reset", int'(status_word), 0);
    check("R13 irq after reset", int'(irq_out), 0);

    cmd(15, 'h1FF);
    cmd(14, 'h1FF);
    // R3 each event pulse
    @(negedge clk); ev_host_err = 1; @(negedge clk); ev_host_err = 0;
    check("R3 host error bit1", int'(status_word[1]), 1);
    check("R6 latch set by enabled cause", int'(status_word[0]), 1);
    check("R7 irq raised", int'(irq_out), 1);
    @(negedge clk); ev_tx_done = 1; ev_rx_done = 1; ev_xfer_done = 1;
    @(negedge clk); ev_tx_done = 0; ev_rx_done = 0; ev_xfer_done = 0;
    check("R3 tx/rx/xfer bits", int'(status_word[8:0]) & 'h115, 'h115);
    @(negedge clk); ev_tx_room = 1; ev_rx_early = 1; ev_stats = 1;
    @(negedge clk); ev_tx_room = 0; ev_rx_early = 0; ev_stats = 0;
    check("R3 room/early/stats bits", int'(status_word[8:0]) & 'h0A8, 'h0A8);
    cmd(12, 0);
    check("R4 request bit6", int'(status_word[6]), 1);
    // R5 ack all
    cmd(13, 'h1FF);
    check("R5 ack clears all", int'(status_word[8:0]), 0);
    check("R7 irq low after ack", int'(irq_out), 0);
    // R5 ack collides with a raising event
    @(negedge clk); ev_tx_done = 1; cmd_wr = 1; cmd_data = {5'h0D, 11'h004};
    @(negedge clk); ev_tx_done = 0; cmd_wr = 0; cmd_data = '0;
    check("R5 raise wins over ack", int'(status_word[2]), 1);
    cmd(13, 'h1FF);
    // R6 disabled cause does not set latch
    cmd(14, 'h000);
    @(negedge clk); ev_rx_done = 1; @(negedge clk); ev_rx_done = 0;
    check("R6 disabled cause no latch", int'(status_word[0]), 0);
    check("R3 cause still recorded", int'(status_word[4]), 1);
    check("R7 irq low when disabled", int'(irq_out), 0);
    // R8 hidden causes still drive irq
    cmd(14, 'h1FF);
    @(negedge clk); ev_stats = 1; @(negedge clk); ev_stats = 0;
    cmd(15, 'h000);
    check("R8 hidden status", int'(status_word[8:0]), 0);
    check("R8 irq unaffected by hiding", int'(irq_out), 1);
    cmd(15, 'h1FF);
    cmd(13, 'h1FF);
    // R2 window, upper argument ignored
    cmd(1, 'h7FD);
    check("R2 window from arg[2:0]", int'(status_word[15:13]), 5);
    // R9, R10
    cmd(16, 'hF);
    check("R9 filter all bits", int'(rx_filter), 'hF);
    cmd(17, 'h5A5); cmd(18, 'h7FF); cmd(19, 'h001);
    check("R10 rx early thr", int'(rx_early_thr), 'h5A5);
    check("R10 tx avail thr", int'(tx_avail_thr), 'h7FF);
    check("R10 tx start thr", int'(tx_start_thr), 'h001);
    // R1 unknown opcode leaves everything alone
    cmd(31, 'h7FF);
    check("R1 unknown opcode status", int'(status_word), 'hA000);
    check("R1 unknown opcode filter", int'(rx_filter), 'hF);
    // R11 busy duration
    begin
      int n;
      cmd(5, 0);
      n = 0;
      while (status_word[12] && n < 100) begin n++; @(negedge clk); end
      check("R11 rx reset busy length", n, NBUSY);
      cmd(11, 0);
      idle(3);
      cmd(11, 0);
      n = 0;
      while (status_word[12] && n < 100) begin n++; @(negedge clk); end
      check("R11 restart busy length", n, NBUSY);
    end
    // R12 global reset meets an event
    @(negedge clk); ev_host_err = 1; cmd_wr = 1; cmd_data = 16'h0000;
    @(negedge clk); ev_host_err = 0; cmd_wr = 0;
    check("R12 state cleared", int'({status_word[15:13], status_word[11:0]}), 0);
    check("R12 busy started", int'(status_word[12]), 1);
    check("R12 thresholds cleared", int'(tx_avail_thr), 0);
    idle(NBUSY + 2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule